// File: doc/BRIEF.md
# Operating Mode Controller with Front-Panel Interlock

This block holds the command word that puts a multi-channel relay-switched module into one of four operating modes: measurement, test, adjustment or idle. Idle is the configuration mode. Only in idle may channel configuration data reach the relay drivers, and only in idle may the front-panel push button reset the module. In the other three modes the button is ignored, so a calibration run, a relay-driver self test or a data collection run cannot be cut short from the panel.

A host reaches the block through a small register bus. The bus has a two-bit word address, write and read strobes and 16-bit data. The command word must be one-hot. A write with more than one mode bit set is refused: the active mode stays as it was, the written value is still kept for readback, and an error flag is raised. The block clears itself to its reset state, with idle active, in three cases: at power-on, when the host requests a soft reset, and when a button press is accepted. An accepted press also drives an active-low interrupt request. That request is held until the host clears it.

Register map (word addresses): 0 is the command register (read/write). 1 is the status register (read only; reading it clears the interrupt). 2 is the error-type register (read only). 3 is the control register. A write to address 3 issues actions, and a read of address 3 returns the active mode and the interrupt state.

Top module: `opmode_ctrl`

## Requirements
- R1: After reset, and with no writes since, the command register reads 0x0008 and address 3 reads 0x0008. The status and error-type registers read 0x0000, `mode_err` is 0, `irq_n` is 1 and `soft_rst` is 0.
- R2: A command write whose low four bits have exactly one bit set makes that mode active. Bit 0 selects measurement, bit 1 test, bit 2 adjustment and bit 3 idle. Address 3 bits 3:0 then show the new one-hot mode. The command register reads back the written bits 3:0, and its bits 15:4 read as 0 whatever was written there.
- R3: A command write with two or more of bits 3:0 set leaves the active mode unchanged and sets `mode_err`. Error-type bit 0 reads 1, and the command register reads back the written bits 3:0.
- R4: Status bit 1 equals the mode error, and status bit 0 reads 0. A later command write with exactly one bit set clears the error.
- R5: A command write with bits 3:0 all zero leaves the active mode and the error flag unchanged. The command register then reads 0.
- R6: `chan_wr_gnt` is 1 only when `chan_wr_req` is 1 and idle is the active mode.
- R7: A press of `btn_in` while idle is active produces one `soft_rst` pulse, one clock long, three clock edges after the input rises. The block returns to its R1 register values, except that `irq_n` goes low and address 3 bit 4 reads 1.
- R8: A press of `btn_in` while measurement, test or adjustment is active is ignored. No `soft_rst` pulse appears, the mode stays the same and `irq_n` stays 1.
- R9: Holding `btn_in` high for many cycles gives exactly one accepted reset.
- R10: The interrupt is cleared, with `irq_n` returning to 1, by a read of the status register or by a write to address 3 with bit 1 set.
- R11: A write to address 3 with bit 0 set gives a `soft_rst` pulse in the following cycle. It restores the R1 values, including `irq_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| addr | input | 2 | Register word address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while rd_en is high |
| btn_in | input | 1 | Debounced front-panel push button, active high |
| chan_wr_req | input | 1 | Channel configuration write attempt |
| chan_wr_gnt | output | 1 | Channel write allowed |
| soft_rst | output | 1 | One-cycle module-wide clear pulse |
| mode_err | output | 1 | Illegal command selection flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A wrong active mode shows up on the very next cycle in two places: a channel grant that is missing or spurious, and a wrong read of address 3. It also shows later as a button press being honoured or dropped when it should not be. A corrupted error flag is visible at once on `mode_err` and in both status registers. A fault in the synchronizer or the edge detector shows as a pulse count other than one per press on `soft_rst`, three edges after the press. Interrupt faults show on `irq_n` in the cycle after a clear or an accepted press.

// File: rtl/opmode_pkg.sv
package opmode_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_MEAS = 4'b0001;
  localparam logic [MODE_W-1:0] MODE_TEST = 4'b0010;
  localparam logic [MODE_W-1:0] MODE_ADJ  = 4'b0100;
  localparam logic [MODE_W-1:0] MODE_IDLE = 4'b1000;

  // number of set bits in a mode word
  function automatic int unsigned bit_count(input logic [MODE_W-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < MODE_W; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic is_legal(input logic [MODE_W-1:0] v);
    return bit_count(v) == 1;
  endfunction

  function automatic logic is_multi(input logic [MODE_W-1:0] v);
    return bit_count(v) > 1;
  endfunction
endpackage

// File: rtl/opmode_btn_edge.sv
module opmode_btn_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_in,
  output logic btn_rise
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;

  // the shift register is not cleared by soft reset, so a held button
  // cannot produce a second rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SH_W-2:0], btn_in};
  end

  assign btn_rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  // two rises need at least one low synchronized sample between them (R9)
  assert_single_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    btn_rise |=> !btn_rise);
endmodule

// File: rtl/opmode_mode_core.sv
module opmode_mode_core
  import opmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cmd_we,
  input  logic [MODE_W-1:0] cmd_wdata,
  output logic [MODE_W-1:0] cmd_rb,
  output logic [MODE_W-1:0] active_mode,
  output logic              mode_err,
  output logic              is_idle
);
  logic legal_write;
  logic multi_write;

  assign legal_write = cmd_we & is_legal(cmd_wdata);
  assign multi_write = cmd_we & is_multi(cmd_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_rb      <= MODE_IDLE;
      active_mode <= MODE_IDLE;
      mode_err    <= 1'b0;
    end else if (clr) begin
      cmd_rb      <= MODE_IDLE;
      active_mode <= MODE_IDLE;
      mode_err    <= 1'b0;
    end else if (cmd_we) begin
      cmd_rb <= cmd_wdata;
      if (legal_write) begin
        active_mode <= cmd_wdata;
        mode_err    <= 1'b0;
      end else if (multi_write) begin
        mode_err <= 1'b1;
      end
    end
  end

  assign is_idle = (active_mode == MODE_IDLE);

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active_mode) == 1);

  assert_retain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_write && !clr) |=> $stable(active_mode));

  assert_err_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_err) |-> $past(multi_write));

  assert_zero_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !clr && cmd_wdata == '0) |=> ($stable(active_mode) && $stable(mode_err)));
endmodule

// File: rtl/opmode_irq.sv
module opmode_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic irq_pend
);
  // a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_pend <= 1'b0;
    else if (set_req) irq_pend <= 1'b1;
    else if (clr_req) irq_pend <= 1'b0;
  end

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req) |=> !irq_pend);

  assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> irq_pend);
endmodule

// File: rtl/opmode_ctrl.sv
module opmode_ctrl
  import opmode_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int CMD_OFS     = 0,
  parameter int STAT_OFS    = 1,
  parameter int STYPE_OFS   = 2,
  parameter int CTRL_OFS    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              btn_in,
  input  logic              chan_wr_req,
  output logic              chan_wr_gnt,
  output logic              soft_rst,
  output logic              mode_err,
  output logic              irq_n
);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(CMD_OFS);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] A_STYPE = ADDR_W'(STYPE_OFS);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_OFS);
  localparam int CTL_RST_BIT  = 0;
  localparam int CTL_ICLR_BIT = 1;
  localparam int STAT_ERR_BIT = 1;

  logic              wr_cmd, wr_ctrl, host_rst, btn_rise, btn_accept, clr_all;
  logic              irq_clr, irq_pend, is_idle, soft_rst_q;
  logic [MODE_W-1:0] cmd_rb, active_mode;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DATA_W-1:MODE_W];

  assign wr_cmd     = wr_en & (addr == A_CMD);
  assign wr_ctrl    = wr_en & (addr == A_CTRL);
  assign host_rst   = wr_ctrl & wdata[CTL_RST_BIT];
  assign btn_accept = btn_rise & is_idle;
  assign clr_all    = host_rst | btn_accept;
  assign irq_clr    = host_rst | (wr_ctrl & wdata[CTL_ICLR_BIT])
                    | (rd_en & (addr == A_STAT));

  opmode_btn_edge #(.SYNC_STAGES(SYNC_STAGES)) u_btn (
    .clk      (clk),
    .rst_n    (rst_n),
    .btn_in   (btn_in),
    .btn_rise (btn_rise)
  );

  opmode_mode_core u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr_all),
    .cmd_we      (wr_cmd),
    .cmd_wdata   (wdata[MODE_W-1:0]),
    .cmd_rb      (cmd_rb),
    .active_mode (active_mode),
    .mode_err    (mode_err),
    .is_idle     (is_idle)
  );

  opmode_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_req  (btn_accept),
    .clr_req  (irq_clr),
    .irq_pend (irq_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_rst_q <= 1'b0;
    else        soft_rst_q <= clr_all;
  end

  assign soft_rst    = soft_rst_q;
  assign irq_n       = ~irq_pend;
  assign chan_wr_gnt = chan_wr_req & is_idle;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        A_CMD:   rdata[MODE_W-1:0] = cmd_rb;
        A_STAT:  rdata[STAT_ERR_BIT] = mode_err;
        A_STYPE: rdata[0] = mode_err;
        default: begin
          rdata[MODE_W-1:0] = active_mode;
          rdata[MODE_W]     = irq_pend;
        end
      endcase
    end
  end

  assert_btn_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_rise && !is_idle && !host_rst) |=> !soft_rst);

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(btn_accept));

  assert_reset_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (is_idle && !mode_err && cmd_rb == MODE_IDLE));

  assert_gnt_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_wr_gnt && !$past(clr_all)) |-> $past(active_mode == MODE_IDLE || legal_idle_wr(wr_cmd, wdata[MODE_W-1:0])));

  function automatic logic legal_idle_wr(input logic we, input logic [MODE_W-1:0] d);
    return we && d == MODE_IDLE;
  endfunction
endmodule

// File: tb/opmode_ctrl_test.sv
`timescale 1ns/1ps
module opmode_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        btn_in = 1'b0, chan_wr_req = 1'b0;
  logic        chan_wr_gnt, soft_rst, mode_err, irq_n;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [3:0] m_mode, m_cmd;
  logic       m_err, m_irq;

  opmode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .btn_in(btn_in), .chan_wr_req(chan_wr_req),
    .chan_wr_gnt(chan_wr_gnt), .soft_rst(soft_rst), .mode_err(mode_err), .irq_n(irq_n)
  );

  always #10 clk = ~clk;

  function automatic int ones4(input logic [3:0] v);
    int n = 0;
    for (int i = 0; i < 4; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic void model_cmd(input logic [3:0] v);
    m_cmd = v;
    if (ones4(v) == 1) begin m_mode = v; m_err = 1'b0; end
    else if (ones4(v) > 1) m_err = 1'b1;
  endfunction

  function automatic void model_reset();
    m_mode = 4'h8; m_cmd = 4'h8; m_err = 1'b0;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #2 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic check_state(input string req);
    logic [15:0] d;
    bus_rd(2'd0, d); chk({req, " cmd"}, d, {12'h0, m_cmd});
    bus_rd(2'd3, d); chk({req, " mode"}, d, {11'h0, m_irq, m_mode});
    bus_rd(2'd2, d); chk({req, " errtype"}, d, {15'h0, m_err});
    chk({req, " mode_err"}, {15'h0, mode_err}, {15'h0, m_err});
    chk({req, " irq_n"}, {15'h0, irq_n}, {15'h0, ~m_irq});
  endtask

  // press the button for hold cycles, return number of soft_rst pulses
  task automatic press(input int hold, output int cnt);
    cnt = 0;
    @(negedge clk); btn_in = 1'b1;
    for (int i = 0; i < hold + 6; i++) begin
      @(negedge clk);
      if (soft_rst) cnt++;
      if (i == hold - 1) btn_in = 1'b0;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int cnt;
    void'($urandom(32'd4242));
    model_reset(); m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_state("R1");
    bus_rd(2'd1, d); chk("R1 status", d, 16'h0000);
    chk("R1 soft_rst", {15'h0, soft_rst}, 16'h0);
    chan_wr_req = 1'b1; #1 chk("R6 idle grant", {15'h0, chan_wr_gnt}, 16'h1);

    // R2 legal write, R6 blocked outside idle
    bus_wr(2'd0, 16'h0001); model_cmd(4'h1);
    check_state("R2 meas");
    chk("R6 meas blocked", {15'h0, chan_wr_gnt}, 16'h0);

    // R8 button ignored in measurement, test, adjustment
    press(3, cnt); chk("R8 meas pulses", 16'(cnt), 16'd0);
    check_state("R8 meas");
    bus_wr(2'd0, 16'h0002); model_cmd(4'h2);
    press(3, cnt); chk("R8 test pulses", 16'(cnt), 16'd0);
    check_state("R8 test");
    bus_wr(2'd0, 16'h0004); model_cmd(4'h4);
    press(3, cnt); chk("R8 adj pulses", 16'(cnt), 16'd0);
    check_state("R8 adj");

    // R3/R4 illegal multi-bit write
    bus_wr(2'd0, 16'h0005); model_cmd(4'h5);
    check_state("R3 multi");
    bus_rd(2'd1, d); chk("R4 status err", d, 16'h0002);

    // R5 zero write
    bus_wr(2'd0, 16'h0000); model_cmd(4'h0);
    check_state("R5 zero");

    // R2/R4 upper bits ignored, legal write clears error
    bus_wr(2'd0, 16'hF002); model_cmd(4'h2);
    check_state("R4 clear");
    bus_rd(2'd1, d); chk("R4 status clear", d, 16'h0000);

    // R7/R9 held button in idle with pending error
    bus_wr(2'd0, 16'h0008); model_cmd(4'h8);
    bus_wr(2'd0, 16'h000C); model_cmd(4'hC);
    press(12, cnt); chk("R9 held pulses", 16'(cnt), 16'd1);
    model_reset(); m_irq = 1'b1;
    check_state("R7 after press");

    // R10 status read clears interrupt
    bus_rd(2'd1, d); chk("R10 status", d, 16'h0000);
    m_irq = 1'b0;
    chk("R10 irq_n read", {15'h0, irq_n}, 16'h1);

    // R7 short press, R10 clear by control write
    press(1, cnt); chk("R7 pulses", 16'(cnt), 16'd1);
    chk("R7 irq_n", {15'h0, irq_n}, 16'h0);
    bus_wr(2'd3, 16'h0002); m_irq = 1'b0;
    chk("R10 irq_n ctrl", {15'h0, irq_n}, 16'h1);
    check_state("R10 after");

    // R11 host soft reset
    bus_wr(2'd0, 16'h0001); model_cmd(4'h1);
    bus_wr(2'd0, 16'h0003); model_cmd(4'h3);
    check_state("R11 pre");
    bus_wr(2'd3, 16'h0001);
    chk("R11 pulse", {15'h0, soft_rst}, 16'h1);
    @(negedge clk); chk("R11 pulse end", {15'h0, soft_rst}, 16'h0);
    model_reset();
    check_state("R11 post");

    // random command writes
    for (int it = 0; it < 200; it++) begin
      logic [15:0] v;
      v = 16'($urandom);
      bus_wr(2'd0, v); model_cmd(v[3:0]);
      chan_wr_req = 1'($urandom);
      #1 chk("R6 random grant", {15'h0, chan_wr_gnt}, {15'h0, chan_wr_req & (m_mode == 4'h8)});
      bus_rd(2'd0, d); chk("R2 random cmd", d, {12'h0, m_cmd});
      bus_rd(2'd3, d); chk("R3 random mode", d, {11'h0, m_irq, m_mode});
      bus_rd(2'd2, d); chk("R4 random err", d, {15'h0, m_err});
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule